// File: doc/BRIEF.md
# Serialized Interrupt Bus Host Sequencer

This block is the host end of a one-wire, open-drain interrupt bus. All agents share the wire, and the bus clock times every step. The host opens each bus cycle with a Start frame. It then steps through a fixed series of three-clock data frames. Each peripheral owns one frame, and in the first clock of its frame it pulls the wire low to report an active request. The host closes the cycle with a Stop frame. The width of the Stop pulse tells every peripheral how the next cycle will begin.

There are two ways a cycle can begin. In Continuous mode the host opens every cycle by itself. In Quiet mode the host leaves the wire released until a peripheral pulls it low. The host then treats that low as the first clock of a Start frame and drives the rest of it. The host publishes the 32 request levels it samples as one vector, together with a one-clock valid strobe. A request input picks the mode that the next Stop frame announces. Before the system is suspended, or before a peripheral is plugged in or removed, the host must be set to Continuous mode.

Top module: `sirq_host`

## Requirements
- R1: While `rst` is high and on the first clock after it, `line_oe_o`, `vec_valid_o` and `irq_vec_o` are all zero. After reset the bus mode is Continuous.
- R2: Without any peripheral activity, the host starts the first cycle after reset by itself. `line_oe_o` goes high on the first clock after reset is released and stays high for 4 clocks (the Start frame).
- R3: The host releases the wire for one clock after the last Start clock. Counting that release clock as clock 1, frame N (N = 1..32) is sampled on clock 3N-1, so frame 1 is sampled on clock 2 and frame 32 on clock 95.
- R4: A low level at a frame's sample clock sets bit N-1 of `irq_vec_o` to 1, and a high level clears it. Frames 22 to 32 carry no assigned source, but they are sampled into bits 21..31 like every other frame.
- R5: `irq_vec_o` is updated only on the first Stop clock. `vec_valid_o` is high for that one clock only, and `irq_vec_o` holds its value at all other times.
- R6: The Stop frame follows clock 97 at once. `line_oe_o` stays high for 3 clocks if `cont_req_i` was 1 on clock 97 (Continuous), and for 2 clocks if it was 0 (Quiet).
- R7: After the Stop frame the wire is released for one clock, and then for one idle clock. If the Stop frame announced Continuous mode, the next Start frame begins on the clock after that.
- R8: In Quiet mode the host does not drive the wire while it stays high. When a low level is seen in idle, the host drives the wire on the next 3 clocks, making a 4-clock Start frame together with the peripheral's clock. Frame timing then follows R3.
- R9: Low levels on the recovery and turnaround clocks of the frames (any clock other than 3N-1) have no effect on `irq_vec_o`.
- R10: The host drives the wire only in Start and Stop frames. `line_oe_o` is low on clocks 1 to 97.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Level sensed on the shared wire |
| cont_req_i | input | 1 | 1 = announce Continuous mode for the next cycle, 0 = Quiet mode |
| line_oe_o | output | 1 | 1 = pull the wire low; 0 = release it |
| irq_vec_o | output | 32 | Latched request levels, bit N-1 for frame N, 1 = asserted |
| vec_valid_o | output | 1 | One-clock strobe when `irq_vec_o` is refreshed |

## Verification
The checks assume that `line_i` is a clean, synchronous copy of the wire. They also assume that a peripheral opening a Quiet-mode cycle holds the wire low for a single clock and then lets the host carry the Start frame. The bench models the wire as the AND of the host's pull-down and one peripheral driver. That driver changes only on falling clock edges, and it starts a cycle only while the host is idle in Quiet mode. `cont_req_i` is changed only well before clock 97, so the announced Stop width is always well defined.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    // Clocks per data frame and the offset of the sample clock within the frame index grid.
    localparam int unsigned FRAME_CLKS = 3;
    localparam int unsigned SAMPLE_OFS = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_FRAMES,
        ST_STOP,
        ST_STOP_TA
    } seq_state_e;

    typedef enum logic {
        MODE_QUIET = 1'b0,
        MODE_CONT  = 1'b1
    } bus_mode_e;

    // Sampling event handed from the sequencer to the capture stage.
    typedef struct packed {
        logic fire;   // sample the wire this clock
        logic close;  // last frame clock: publish the vector
    } samp_evt_t;

    // Clock (counted from the release clock as 1) where frame index idx is sampled.
    function automatic int unsigned frame_sample_tick(int unsigned idx);
        return FRAME_CLKS * idx + SAMPLE_OFS;
    endfunction

    // Stop frame low width that announces the given mode.
    function automatic logic [1:0] stop_clocks(bus_mode_e m);
        return (m == MODE_CONT) ? 2'd3 : 2'd2;
    endfunction

endpackage

// File: rtl/sirq_seq.sv
module sirq_seq
    import sirq_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 32,
    parameter int unsigned START_LEN  = 4,
    parameter int unsigned IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    input  logic             cont_req_i,
    output logic             oe_o,
    output samp_evt_t        evt_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam int unsigned LAST_TICK = FRAME_CLKS * NUM_FRAMES + 1;
    localparam int unsigned TICK_W    = $clog2(LAST_TICK + 1);
    localparam int unsigned CNT_W     = (START_LEN > 4) ? $clog2(START_LEN) : 2;

    seq_state_e         state_q;
    bus_mode_e          mode_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [TICK_W-1:0]  tick_q;
    logic [IDX_W-1:0]   fidx_q;
    logic               oe_q;
    logic               in_frames;
    logic               last_tick;

    assign in_frames  = (state_q == ST_FRAMES);
    assign last_tick  = in_frames && (tick_q == TICK_W'(LAST_TICK));
    assign evt_o.fire = in_frames &&
                        (32'(tick_q) == frame_sample_tick(32'(fidx_q)));
    assign evt_o.close = last_tick;
    assign idx_o      = fidx_q;
    assign oe_o       = oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_CONT;
            cnt_q   <= '0;
            tick_q  <= '0;
            fidx_q  <= '0;
            oe_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (mode_q == MODE_CONT) begin
                        state_q <= ST_START;
                        cnt_q   <= '0;
                        oe_q    <= 1'b1;
                    end else if (!line_i) begin
                        // A peripheral supplied the first Start clock.
                        state_q <= ST_START;
                        cnt_q   <= CNT_W'(1);
                        oe_q    <= 1'b1;
                    end
                end
                ST_START: begin
                    if (cnt_q == CNT_W'(START_LEN - 1)) begin
                        state_q <= ST_FRAMES;
                        tick_q  <= TICK_W'(1);
                        fidx_q  <= '0;
                        oe_q    <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_FRAMES: begin
                    if (evt_o.fire) begin
                        fidx_q <= fidx_q + 1'b1;
                    end
                    if (last_tick) begin
                        state_q <= ST_STOP;
                        cnt_q   <= '0;
                        mode_q  <= cont_req_i ? MODE_CONT : MODE_QUIET;
                        oe_q    <= 1'b1;
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (cnt_q == CNT_W'(stop_clocks(mode_q) - 2'd1)) begin
                        state_q <= ST_STOP_TA;
                        oe_q    <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_STOP_TA: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                    oe_q    <= 1'b0;
                end
            endcase
        end
    end

    // R10: the wire is never pulled while data frames run.
    assert_no_drive_frames_R10: assert property (@(posedge clk) disable iff (rst)
        in_frames |-> !oe_q);

    // R7: a Continuous-mode idle clock is always followed by a Start clock.
    assert_cont_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && mode_q == MODE_CONT) |=> (state_q == ST_START && oe_q));

    // R8: in Quiet mode an idle, high wire keeps the host idle and released.
    assert_quiet_wait_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && mode_q == MODE_QUIET && line_i) |=> (state_q == ST_IDLE && !oe_q));

    // R6: the Stop frame begins right after the last frame clock.
    assert_stop_follows_R6: assert property (@(posedge clk) disable iff (rst)
        last_tick |=> (state_q == ST_STOP && oe_q));

endmodule

// File: rtl/sirq_capture.sv
module sirq_capture
    import sirq_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 32,
    parameter int unsigned IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  line_i,
    input  samp_evt_t             evt_i,
    input  logic [IDX_W-1:0]      idx_i,
    output logic [NUM_FRAMES-1:0] vec_o,
    output logic                  valid_o
);

    logic [NUM_FRAMES-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            vec_o    <= '0;
            valid_o  <= 1'b0;
        end else begin
            if (evt_i.fire) begin
                shadow_q[idx_i] <= ~line_i;
            end
            valid_o <= evt_i.close;
            if (evt_i.close) begin
                vec_o <= shadow_q;
            end
        end
    end

    // R5: the strobe lasts a single clock.
    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R5: the published vector only moves together with the strobe.
    assert_vec_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(vec_o));

    // R3: sample clocks are never adjacent.
    assert_sample_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        evt_i.fire |=> !evt_i.fire);

endmodule

// File: rtl/sirq_host.sv
module sirq_host
    import sirq_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 32,
    parameter int unsigned START_LEN  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  line_i,
    input  logic                  cont_req_i,
    output logic                  line_oe_o,
    output logic [NUM_FRAMES-1:0] irq_vec_o,
    output logic                  vec_valid_o
);

    localparam int unsigned IDX_W = $clog2(NUM_FRAMES);

    samp_evt_t        evt;
    logic [IDX_W-1:0] fidx;

    sirq_seq #(
        .NUM_FRAMES(NUM_FRAMES),
        .START_LEN (START_LEN),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .line_i    (line_i),
        .cont_req_i(cont_req_i),
        .oe_o      (line_oe_o),
        .evt_o     (evt),
        .idx_o     (fidx)
    );

    sirq_capture #(
        .NUM_FRAMES(NUM_FRAMES),
        .IDX_W     (IDX_W)
    ) u_cap (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_i),
        .evt_i  (evt),
        .idx_i  (fidx),
        .vec_o  (irq_vec_o),
        .valid_o(vec_valid_o)
    );

    // R5: the new vector is presented while the Stop frame pulls the wire.
    assert_valid_in_stop_R5: assert property (@(posedge clk) disable iff (rst)
        vec_valid_o |-> line_oe_o);

endmodule

// File: tb/sim_sirq_host.sv
module sim_sirq_host;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        per_line = 1'b1;
    logic        cont_req = 1'b1;
    logic        line;
    logic        oe;
    logic [31:0] vec;
    logic        valid;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    logic [31:0] last_vec = '0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    assign line = oe ? 1'b0 : per_line;

    sirq_host u0 (
        .clk       (clk),
        .rst       (rst),
        .line_i    (line),
        .cont_req_i(cont_req),
        .line_oe_o (oe),
        .irq_vec_o (vec),
        .vec_valid_o(valid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Scoreboard monitor: compares each published vector with the queue (R4, R5, R9).
    always @(negedge clk) begin
        if (!rst) begin
            if (valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected strobe", vec, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check(vec == e, "R4/R9 vector", vec, e);
                end
                last_vec = vec;
            end else begin
                check(vec == last_vec, "R5 hold", vec, last_vec);
            end
        end
    end

    // Driver: runs one bus cycle as the peripherals, pushes the expected vector.
    task automatic run_cycle(input logic [31:0] pat, input bit cont_next,
                             input bit noise, input bit quiet_entry);
        int start_len;
        cont_req = cont_next;
        if (quiet_entry) begin
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                check(oe == 1'b0, "R8 quiet idle", 32'(oe), 32'h0);
            end
            per_line = 1'b0;
            @(negedge clk);
            per_line  = 1'b1;
            start_len = 3;
        end else begin
            int guard = 0;
            while (oe !== 1'b1 && guard < 20) begin
                @(negedge clk);
                guard++;
            end
            start_len = 4;
        end
        for (int i = 0; i < start_len; i++) begin
            check(oe == 1'b1, "R2/R8 start drive", 32'(oe), 32'h1);
            @(negedge clk);
        end
        exp_q.push_back(pat);
        for (int k = 1; k <= 97; k++) begin
            check(oe == 1'b0, "R10 released in frames", 32'(oe), 32'h0);
            if (k % 3 == 2) per_line = ~pat[(k + 1) / 3 - 1];
            else            per_line = noise ? 1'b0 : 1'b1;
            @(negedge clk);
        end
        per_line = 1'b1;
        for (int i = 0; i < (cont_next ? 3 : 2); i++) begin
            check(oe == 1'b1, "R6 stop width", 32'(oe), 32'h1);
            @(negedge clk);
        end
        check(oe == 1'b0, "R6/R7 stop release", 32'(oe), 32'h0);
        @(negedge clk);
        check(oe == 1'b0, "R7 idle clock", 32'(oe), 32'h0);
        if (cont_next) begin
            @(negedge clk);
            check(oe == 1'b1, "R7 continuous restart", 32'(oe), 32'h1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(oe == 1'b0 && valid == 1'b0 && vec == 32'h0, "R1 reset state",
              {oe, valid, vec[29:0]}, 32'h0);
        rst = 1'b0;
        check(oe == 1'b0 && vec == 32'h0, "R1 first clock", 32'(oe), 32'h0);
        @(negedge clk);
        check(oe == 1'b1, "R2 self start", 32'(oe), 32'h1);
        run_cycle(32'h0000_0000, 1'b1, 1'b0, 1'b0);
        run_cycle(32'hA5A5_0F0F, 1'b1, 1'b1, 1'b0);
        run_cycle(32'hFFE0_0000, 1'b0, 1'b1, 1'b0);
        run_cycle(32'h0020_0001, 1'b0, 1'b0, 1'b1);
        run_cycle(32'h8000_0003, 1'b1, 1'b1, 1'b1);
        run_cycle(32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);
        run_cycle(32'h0000_0001, 1'b1, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R5 all vectors published", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule